// File: doc/BRIEF.md
# ADC Result Window Monitor

This block sits on the result path of an analog-to-digital converter and watches each completed conversion. Each result arrives with a valid strobe, its channel number and a flag that says whether it was taken at reduced resolution. The block tests the result against a low and a high threshold, in one of four region modes. It raises a sticky event once a programmed run of back-to-back qualifying results has been seen.

Thresholds are always given at the full 12-bit scale. A 10-bit result is scaled up before the test, so software never rescales the thresholds. The test can cover every channel or a single chosen one. Results from channels that are not chosen are ignored entirely. The event stays set until a status read clears it. It drives an interrupt line through an enable bit.

Top module: `adc_window_monitor`

## Requirements
- R1: With mode code 0, a checked result counts as a hit when it is strictly less than the low threshold.
- R2: With mode code 1, a checked result counts as a hit when it is strictly greater than the high threshold.
- R3: With mode code 2, a checked result counts as a hit when it lies between the low and high thresholds, both ends included.
- R4: With mode code 3, a checked result counts as a hit when it is below the low threshold or above the high threshold.
- R5: When `cfg_all_chan` is 1, every valid result is checked. When it is 0, only results whose `res_chan` equals `cfg_chan` are checked. Results that are not checked leave the run counter unchanged.
- R6: With filter value N in `cfg_filter`, the event sets on the (N+1)th consecutive checked hit, so N=0 sets it on the first hit. A checked result that misses resets the run to zero.
- R7: When `res_lowres` is 1, the low 10 bits of `res_data` are shifted left by 2 before they are compared with the 12-bit thresholds.
- R8: `evt_flag` rises in the cycle after the qualifying result and then stays high. It clears in the cycle after `stat_rd` is pulsed. If a new event and a read fall in the same cycle, the flag stays set.
- R9: When the event fires, the run counter restarts from zero. After a clear, a full new run of N+1 hits is needed to set the flag again.
- R10: `irq` is high exactly when `evt_flag` is high and `cfg_irq_en` is 1.
- R11: After reset, `evt_flag` and `irq` are 0 and the run counter is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_chan | input | 4 | Channel of the result |
| res_data | input | 12 | Result value, right aligned |
| res_lowres | input | 1 | Result has 10-bit resolution |
| cfg_mode | input | 2 | Region mode: 0 below, 1 above, 2 inside, 3 outside |
| cfg_all_chan | input | 1 | Check every channel |
| cfg_chan | input | 4 | Channel checked when not all |
| cfg_filter | input | 4 | Consecutive hits needed, minus one |
| cfg_thr_lo | input | 12 | Low threshold, full scale |
| cfg_thr_hi | input | 12 | High threshold, full scale |
| cfg_irq_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | Status read pulse; clears the event |
| evt_flag | output | 1 | Sticky window event |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the flag in the same cycle. One is the set caused by the final hit of a run. The other is the clear caused by a status read. The bench pulses `stat_rd` in the same cycle as the closing hit of a run. It expects the flag to remain high afterwards, and it expects a later read on its own to clear the flag. A behavioural model, updated on every clock, judges both of these cases and all other cycles.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;
    typedef enum logic [1:0] {
        WM_BELOW   = 2'd0,
        WM_ABOVE   = 2'd1,
        WM_INSIDE  = 2'd2,
        WM_OUTSIDE = 2'd3
    } win_mode_e;
endpackage

// File: rtl/adc_win_cmp.sv
module adc_win_cmp #(
    parameter int FULL_W = 12,
    parameter int LOW_W  = 10
) (
    input  logic [FULL_W-1:0] data,
    input  logic              lowres,
    input  logic [1:0]        mode,
    input  logic [FULL_W-1:0] thr_lo,
    input  logic [FULL_W-1:0] thr_hi,
    output logic              hit
);
    import adc_win_pkg::*;
    localparam int SHIFT = FULL_W - LOW_W;

    logic [FULL_W-1:0] norm;
    logic              below, above;

    // scale a reduced-resolution sample up to full scale (R7)
    generate
        if (SHIFT > 0) begin : g_scale
            always_comb begin
                norm = lowres ? {data[LOW_W-1:0], {SHIFT{1'b0}}} : data;
            end
        end else begin : g_noscale
            always_comb begin
                norm = data;
            end
        end
    endgenerate

    always_comb begin
        below = norm < thr_lo;
        above = norm > thr_hi;
        unique case (win_mode_e'(mode))
            WM_BELOW:   hit = below;            // R1
            WM_ABOVE:   hit = above;            // R2
            WM_INSIDE:  hit = !below && !above; // R3
            WM_OUTSIDE: hit = below || above;   // R4
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_win_sel.sv
module adc_win_sel #(
    parameter int CH_W = 4
) (
    input  logic            valid,
    input  logic [CH_W-1:0] chan,
    input  logic [CH_W-1:0] sel_chan,
    input  logic            all_chan,
    output logic            checked
);
    always_comb begin
        checked = valid && (all_chan || (chan == sel_chan)); // R5
    end
endmodule

// File: rtl/adc_win_filter.sv
module adc_win_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              checked,
    input  logic              hit,
    input  logic [FILT_W-1:0] filter,
    input  logic              stat_rd,
    output logic              flag
);
    typedef struct packed {
        logic [FILT_W-1:0] cnt;
        logic              flag;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic        fire_d;

    always_comb begin
        st_d   = st_q;
        fire_d = 1'b0;
        if (checked) begin
            if (hit) begin
                if (st_q.cnt >= filter) begin
                    fire_d   = 1'b1;
                    st_d.cnt = '0;                 // R9
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;    // R6
                end
            end else begin
                st_d.cnt = '0;                     // R6
            end
        end
        if (fire_d)       st_d.flag = 1'b1;        // R8 set wins
        else if (stat_rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;                    // R11
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    p_fire_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (checked && hit && st_q.cnt >= filter) |=> flag);
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(checked && hit)) |=> !flag);
    p_miss_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (checked && !hit) |=> st_q.cnt == '0);
    p_unchecked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !checked |=> $stable(st_q.cnt));
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (checked && hit && st_q.cnt >= filter) |=> st_q.cnt == '0);
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_rd) |=> flag);
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor #(
    parameter int FULL_W = 12,
    parameter int LOW_W  = 10,
    parameter int CH_W   = 4,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [FULL_W-1:0] res_data,
    input  logic              res_lowres,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_all_chan,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [FULL_W-1:0] cfg_thr_lo,
    input  logic [FULL_W-1:0] cfg_thr_hi,
    input  logic              cfg_irq_en,
    input  logic              stat_rd,
    output logic              evt_flag,
    output logic              irq
);
    logic checked, hit;

    adc_win_sel #(.CH_W(CH_W)) u_sel (
        .valid    (res_valid),
        .chan     (res_chan),
        .sel_chan (cfg_chan),
        .all_chan (cfg_all_chan),
        .checked  (checked)
    );

    adc_win_cmp #(.FULL_W(FULL_W), .LOW_W(LOW_W)) u_cmp (
        .data   (res_data),
        .lowres (res_lowres),
        .mode   (cfg_mode),
        .thr_lo (cfg_thr_lo),
        .thr_hi (cfg_thr_hi),
        .hit    (hit)
    );

    adc_win_filter #(.FILT_W(FILT_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .checked (checked),
        .hit     (hit),
        .filter  (cfg_filter),
        .stat_rd (stat_rd),
        .flag    (evt_flag)
    );

    assign irq = evt_flag && cfg_irq_en;   // R10

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_flag && cfg_irq_en));
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> !evt_flag);
endmodule

// File: tb/adc_window_monitor_tb.sv
`timescale 1ns/1ps
module adc_window_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [3:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic        res_lowres = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_all_chan = 1'b1;
    logic [3:0]  cfg_chan = '0;
    logic [3:0]  cfg_filter = '0;
    logic [11:0] cfg_thr_lo = 12'd1000;
    logic [11:0] cfg_thr_hi = 12'd3000;
    logic        cfg_irq_en = 1'b1;
    logic        stat_rd = 1'b0;
    logic        evt_flag, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string tag = "R11";

    int  m_cnt = 0;
    bit  m_flag = 1'b0;

    always #4 clk = ~clk;

    adc_window_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .res_lowres(res_lowres), .cfg_mode(cfg_mode),
        .cfg_all_chan(cfg_all_chan), .cfg_chan(cfg_chan), .cfg_filter(cfg_filter),
        .cfg_thr_lo(cfg_thr_lo), .cfg_thr_hi(cfg_thr_hi), .cfg_irq_en(cfg_irq_en),
        .stat_rd(stat_rd), .evt_flag(evt_flag), .irq(irq)
    );

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_flag = 1'b0;
        end else begin
            int v;
            bit sel, h, fire;
            v    = res_lowres ? (int'(res_data) % 1024) * 4 : int'(res_data);
            sel  = res_valid && (cfg_all_chan || res_chan == cfg_chan);
            case (cfg_mode)
                2'd0: h = v < cfg_thr_lo;
                2'd1: h = v > cfg_thr_hi;
                2'd2: h = v >= cfg_thr_lo && v <= cfg_thr_hi;
                default: h = v < cfg_thr_lo || v > cfg_thr_hi;
            endcase
            fire = 1'b0;
            if (sel) begin
                if (!h) m_cnt = 0;
                else if (m_cnt >= cfg_filter) begin fire = 1'b1; m_cnt = 0; end
                else m_cnt++;
            end
            if (fire) m_flag = 1'b1;
            else if (stat_rd) m_flag = 1'b0;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({tag, " flag/model"}, evt_flag, m_flag);
            chk({tag, " irq/model"}, irq, m_flag && cfg_irq_en);
        end
    end

    task automatic send(input logic [3:0] ch, input logic [11:0] d, input logic lr);
        @(negedge clk);
        res_valid = 1'b1; res_chan = ch; res_data = d; res_lowres = lr;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 flag after reset", evt_flag, 1'b0);
        chk("R11 irq after reset", irq, 1'b0);
        rst_n = 1'b1;

        tag = "R1"; cfg_mode = 2'd0;
        send(0, 12'd1000, 0); chk("R1 equal to low no hit", evt_flag, 1'b0);
        send(0, 12'd999, 0);  chk("R1 below low hit", evt_flag, 1'b1);
        rd(); chk("R8 read clears", evt_flag, 1'b0);

        tag = "R2"; cfg_mode = 2'd1;
        send(1, 12'd3000, 0); chk("R2 equal to high no hit", evt_flag, 1'b0);
        send(1, 12'd3001, 0); chk("R2 above high hit", evt_flag, 1'b1);
        rd();

        tag = "R3"; cfg_mode = 2'd2;
        send(2, 12'd3001, 0); chk("R3 above window no hit", evt_flag, 1'b0);
        send(2, 12'd1000, 0); chk("R3 low edge hit", evt_flag, 1'b1);
        rd();
        send(2, 12'd3000, 0); chk("R3 high edge hit", evt_flag, 1'b1);
        rd();

        tag = "R4"; cfg_mode = 2'd3;
        send(3, 12'd2000, 0); chk("R4 inside no hit", evt_flag, 1'b0);
        send(3, 12'd4000, 0); chk("R4 outside hit", evt_flag, 1'b1);
        rd();

        tag = "R5"; cfg_mode = 2'd0; cfg_all_chan = 1'b0; cfg_chan = 4'd5; cfg_filter = 4'd1;
        send(3, 12'd500, 0); send(3, 12'd500, 0);
        chk("R5 unselected channel ignored", evt_flag, 1'b0);
        send(5, 12'd500, 0); send(3, 12'd2000, 0); send(5, 12'd500, 0);
        chk("R5 unselected miss keeps run", evt_flag, 1'b1);
        rd();
        cfg_all_chan = 1'b1;

        tag = "R6"; cfg_filter = 4'd2;
        send(0, 12'd10, 0); send(0, 12'd10, 0); send(0, 12'd2000, 0);
        send(0, 12'd10, 0); send(0, 12'd10, 0);
        chk("R6 miss restarts run", evt_flag, 1'b0);
        send(0, 12'd10, 0);
        chk("R6 third consecutive hit", evt_flag, 1'b1);
        rd();

        tag = "R7"; cfg_filter = 4'd0; cfg_mode = 2'd1;
        send(0, 12'd750, 1); chk("R7 lowres 750 scales to 3000", evt_flag, 1'b0);
        send(0, 12'd751, 1); chk("R7 lowres 751 scales to 3004", evt_flag, 1'b1);
        rd();
        cfg_mode = 2'd0; cfg_thr_lo = 12'd8;
        send(0, 12'hC01, 1); chk("R7 lowres upper bits dropped", evt_flag, 1'b1);
        rd();
        cfg_thr_lo = 12'd1000;

        tag = "R8"; cfg_filter = 4'd1;
        send(0, 12'd10, 0);
        @(negedge clk);
        res_valid = 1'b1; res_chan = 0; res_data = 12'd10; stat_rd = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; stat_rd = 1'b0;
        chk("R8 set wins over same-cycle read", evt_flag, 1'b1);
        repeat (4) @(negedge clk);
        chk("R8 flag sticky", evt_flag, 1'b1);
        rd(); chk("R8 later read clears", evt_flag, 1'b0);

        tag = "R9";
        send(0, 12'd10, 0); send(0, 12'd10, 0);
        chk("R9 first run fires", evt_flag, 1'b1);
        rd();
        send(0, 12'd10, 0); chk("R9 one hit after fire not enough", evt_flag, 1'b0);
        send(0, 12'd10, 0); chk("R9 new full run fires", evt_flag, 1'b1);

        tag = "R10";
        cfg_irq_en = 1'b0; @(negedge clk);
        chk("R10 irq masked", irq, 1'b0);
        cfg_irq_en = 1'b1; @(negedge clk);
        chk("R10 irq enabled", irq, 1'b1);
        rd(); chk("R10 irq follows clear", irq, 1'b0);

        tag = "R11"; rst_n = 1'b0;
        send(0, 12'd10, 0);
        chk("R11 reset holds flag low", evt_flag, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule